// File: doc/BRIEF.md
# SPI Flash Boot Loader

This block brings up a controller from an external SPI serial flash. When reset is released it waits out the minimum chip-select high time. It then opens a Fast Read on chip select 0 and fetches an 8-byte header from flash address 0. The header tells it where the boot image sits in flash and how many bytes it has.

The block checks the length. If it is acceptable, the block waits out the chip-select high time again and issues a second Fast Read at the image address. It then keeps the clock running while the flash auto-increments its address. Each received byte is written into on-chip program memory through a plain address/data/write-enable port, at consecutive addresses from 0.

A sticky done flag goes high with the final write. A bad length sets a sticky error flag instead and nothing is loaded. The link is SPI mode 0 with a fixed clock derived from the system clock by an even divider. The second chip select and the flash hold and write-protect pins are never driven active.

Top module: `spi_boot_loader`

## Requirements
- R1: SPI mode 0: `spi_sclk_o` is low whenever `spi_cs0_no` is high, `spi_mosi_o` does not change while `spi_sclk_o` is high, and every clock high phase lasts exactly CLK_DIV/2 system clock cycles.
- R2: The first transaction after reset sends, most significant bit first, the opcode 0x0B, then three address bytes 0x00 0x00 0x00, then one dummy byte, and then clocks exactly 8 data bytes before raising `spi_cs0_no`.
- R3: Header decoding: header bytes 0..2 form the image flash address, least significant byte first, and byte 3 is ignored. Header bytes 4..7 form the 32-bit image length in bytes, least significant byte first.
- R4: For a valid length, exactly one more transaction follows. It sends opcode 0x0B, then the 24-bit image address most significant byte first, then one dummy byte, and then clocks exactly `length` data bytes with chip select held low throughout.
- R5: Each image byte is written once to program memory, with `pmem_data_o` equal to the flash byte. The n-th image byte (counting from 0) goes to address n. Each byte gets a write-enable pulse one cycle wide.
- R6: `boot_done_o` rises in the same cycle as the final write-enable pulse and stays high until reset.
- R7: A length of 0, or any 32-bit length greater than MEM_DEPTH, raises `boot_error_o` and keeps it high until reset. In that case no second transaction is issued, no write is made and `boot_done_o` stays low.
- R8: `spi_cs1_no` is high at all times.
- R9: Before every falling edge of `spi_cs0_no`, including the first one after reset, chip select 0 has been high for at least CS_HIGH_NS. The block counts this in system clocks of CLK_PERIOD_NS.
- R10: While reset is asserted, both chip selects are high, the SPI clock is low, no write is issued, and done and error are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| spi_sclk_o | output | 1 | SPI clock, idles low |
| spi_cs0_no | output | 1 | Chip select 0, active low, boot flash |
| spi_cs1_no | output | 1 | Chip select 1, active low, held inactive |
| spi_mosi_o | output | 1 | Serial data to flash |
| spi_miso_i | input | 1 | Serial data from flash |
| pmem_addr_o | output | $clog2(MEM_DEPTH) | Program memory write address |
| pmem_data_o | output | 8 | Program memory write data |
| pmem_we_o | output | 1 | Program memory write enable, one pulse per byte |
| boot_done_o | output | 1 | Sticky image-loaded flag |
| boot_error_o | output | 1 | Sticky bad-header flag |

## Verification
The bench builds the block with CLK_DIV=4, MEM_DEPTH=64 and a 10 ns clock. This gives a two-cycle clock high phase that can be measured, and a 30-cycle chip-select gap. With a 64-byte memory, a full-depth image of 64 bytes and a one-over length of 65 can both be run in a short time. So can a length whose low bits look legal but whose upper bits make it too large. Further cases cover a one-byte image at the top of the 24-bit flash space and a header whose ignored fourth byte is non-zero.

// File: rtl/boot_pkg.sv
package boot_pkg;
  localparam logic [7:0] FAST_READ_OP = 8'h0B;
  localparam int PRE_BYTES = 5;  // opcode + 3 address + dummy
  localparam int HDR_BYTES = 8;

  typedef enum logic [2:0] {
    ST_WAIT_HDR,
    ST_HDR,
    ST_CHECK,
    ST_WAIT_IMG,
    ST_IMG,
    ST_DONE,
    ST_FAIL
  } boot_state_e;
endpackage

// File: rtl/spi_byte_engine.sv
module spi_byte_engine #(
  parameter int CLK_DIV = 4
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       start_i,
  input  logic [7:0] tx_byte_i,
  input  logic       miso_i,
  output logic       busy_o,
  output logic       done_o,
  output logic [7:0] rx_byte_o,
  output logic       sclk_o,
  output logic       mosi_o
);
  localparam int HALF = CLK_DIV / 2;
  localparam int CW   = (HALF > 1) ? $clog2(HALF) : 1;

  logic [CW-1:0] cnt_q;
  logic [2:0]    bit_q;
  logic [7:0]    tx_q, rx_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_o <= 1'b0;
      done_o <= 1'b0;
      sclk_o <= 1'b0;
      cnt_q  <= '0;
      bit_q  <= '0;
      tx_q   <= '0;
      rx_q   <= '0;
    end else begin
      done_o <= 1'b0;
      if (!busy_o) begin
        if (start_i) begin
          busy_o <= 1'b1;
          tx_q   <= tx_byte_i;
          cnt_q  <= '0;
          bit_q  <= '0;
          sclk_o <= 1'b0;
        end
      end else if (cnt_q == CW'(HALF - 1)) begin
        cnt_q <= '0;
        if (!sclk_o) begin
          sclk_o <= 1'b1;
          rx_q   <= {rx_q[6:0], miso_i};
        end else begin
          sclk_o <= 1'b0;
          if (bit_q == 3'd7) begin
            busy_o <= 1'b0;
            done_o <= 1'b1;
          end else begin
            bit_q <= bit_q + 3'd1;
            tx_q  <= {tx_q[6:0], 1'b0};
          end
        end
      end else begin
        cnt_q <= cnt_q + 1'b1;
      end
    end
  end

  assign mosi_o    = tx_q[7];
  assign rx_byte_o = rx_q;
endmodule

// File: rtl/cs_gap_timer.sv
module cs_gap_timer #(
  parameter int GAP_CYC = 30
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic cs_n_i,
  output logic ready_o
);
  localparam int GAP = (GAP_CYC > 0) ? GAP_CYC : 1;
  localparam int CW  = $clog2(GAP + 1);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                   cnt_q <= '0;
    else if (!cs_n_i)              cnt_q <= '0;
    else if (cnt_q != CW'(GAP))    cnt_q <= cnt_q + 1'b1;
  end

  assign ready_o = (cnt_q == CW'(GAP));
endmodule

// File: rtl/spi_boot_loader.sv
module spi_boot_loader
  import boot_pkg::*;
#(
  parameter int CLK_DIV       = 4,
  parameter int CLK_PERIOD_NS = 10,
  parameter int CS_HIGH_NS    = 300,
  parameter int MEM_DEPTH     = 64
) (
  input  logic                         clk_i,
  input  logic                         rst_ni,
  output logic                         spi_sclk_o,
  output logic                         spi_cs0_no,
  output logic                         spi_cs1_no,
  output logic                         spi_mosi_o,
  input  logic                         spi_miso_i,
  output logic [$clog2(MEM_DEPTH)-1:0] pmem_addr_o,
  output logic [7:0]                   pmem_data_o,
  output logic                         pmem_we_o,
  output logic                         boot_done_o,
  output logic                         boot_error_o
);
  localparam int AW      = $clog2(MEM_DEPTH);
  localparam int MAXB    = (MEM_DEPTH > HDR_BYTES) ? MEM_DEPTH : HDR_BYTES;
  localparam int DCW     = $clog2(MAXB + 1);
  localparam int GAP_CYC = (CS_HIGH_NS + CLK_PERIOD_NS - 1) / CLK_PERIOD_NS;

  boot_state_e     state_q;
  logic            cs0_q;
  logic [2:0]      pre_q;
  logic [DCW-1:0]  dcnt_q;
  logic [23:0]     img_addr_q;
  logic [31:0]     img_len_q;
  logic [AW-1:0]   waddr_q;
  logic [7:0]      wdata_q;
  logic            we_q;

  logic            eng_busy, eng_done, gap_ready, eng_start;
  logic [7:0]      eng_rx, tx_byte;
  logic [23:0]     xfer_addr;
  logic [DCW-1:0]  target;
  logic            in_xfer, in_pre, last_byte;

  assign in_xfer   = (state_q == ST_HDR) || (state_q == ST_IMG);
  assign in_pre    = pre_q < 3'(PRE_BYTES);
  assign xfer_addr = (state_q == ST_IMG) ? img_addr_q : 24'h0;
  assign target    = (state_q == ST_HDR) ? DCW'(HDR_BYTES) : img_len_q[DCW-1:0];
  assign last_byte = !in_pre && (DCW'(dcnt_q + 1'b1) == target);
  // one idle cycle between bytes keeps the byte index settled
  assign eng_start = in_xfer && !eng_busy && !eng_done;

  always_comb begin
    unique case (pre_q)
      3'd0:    tx_byte = FAST_READ_OP;
      3'd1:    tx_byte = xfer_addr[23:16];
      3'd2:    tx_byte = xfer_addr[15:8];
      3'd3:    tx_byte = xfer_addr[7:0];
      default: tx_byte = 8'h00;
    endcase
  end

  spi_byte_engine #(.CLK_DIV(CLK_DIV)) i_engine (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .start_i   (eng_start),
    .tx_byte_i (tx_byte),
    .miso_i    (spi_miso_i),
    .busy_o    (eng_busy),
    .done_o    (eng_done),
    .rx_byte_o (eng_rx),
    .sclk_o    (spi_sclk_o),
    .mosi_o    (spi_mosi_o)
  );

  cs_gap_timer #(.GAP_CYC(GAP_CYC)) i_gap (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .cs_n_i  (cs0_q),
    .ready_o (gap_ready)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q    <= ST_WAIT_HDR;
      cs0_q      <= 1'b1;
      pre_q      <= '0;
      dcnt_q     <= '0;
      img_addr_q <= '0;
      img_len_q  <= '0;
      waddr_q    <= '0;
      wdata_q    <= '0;
      we_q       <= 1'b0;
    end else begin
      we_q <= 1'b0;
      unique case (state_q)
        ST_WAIT_HDR, ST_WAIT_IMG: if (gap_ready) begin
          cs0_q   <= 1'b0;
          pre_q   <= '0;
          dcnt_q  <= '0;
          state_q <= (state_q == ST_WAIT_HDR) ? ST_HDR : ST_IMG;
        end
        ST_HDR: if (eng_done) begin
          if (in_pre) pre_q <= pre_q + 3'd1;
          else begin
            unique case (dcnt_q[2:0])
              3'd0: img_addr_q[7:0]   <= eng_rx;
              3'd1: img_addr_q[15:8]  <= eng_rx;
              3'd2: img_addr_q[23:16] <= eng_rx;
              3'd3: ;
              3'd4: img_len_q[7:0]    <= eng_rx;
              3'd5: img_len_q[15:8]   <= eng_rx;
              3'd6: img_len_q[23:16]  <= eng_rx;
              3'd7: img_len_q[31:24]  <= eng_rx;
            endcase
            if (last_byte) begin
              cs0_q   <= 1'b1;
              state_q <= ST_CHECK;
            end else dcnt_q <= dcnt_q + 1'b1;
          end
        end
        ST_CHECK:
          if (img_len_q == 32'd0 || img_len_q > 32'(MEM_DEPTH)) state_q <= ST_FAIL;
          else                                                   state_q <= ST_WAIT_IMG;
        ST_IMG: if (eng_done) begin
          if (in_pre) pre_q <= pre_q + 3'd1;
          else begin
            we_q    <= 1'b1;
            waddr_q <= dcnt_q[AW-1:0];
            wdata_q <= eng_rx;
            if (last_byte) begin
              cs0_q   <= 1'b1;
              state_q <= ST_DONE;
            end else dcnt_q <= dcnt_q + 1'b1;
          end
        end
        default: ;
      endcase
    end
  end

  assign spi_cs0_no   = cs0_q;
  assign spi_cs1_no   = 1'b1;
  assign pmem_addr_o  = waddr_q;
  assign pmem_data_o  = wdata_q;
  assign pmem_we_o    = we_q;
  assign boot_done_o  = (state_q == ST_DONE);
  assign boot_error_o = (state_q == ST_FAIL);
endmodule

// File: rtl/spi_boot_loader_chk.sv
module spi_boot_loader_chk #(
  parameter int CLK_PERIOD_NS = 10,
  parameter int CS_HIGH_NS    = 300
) (
  input logic clk_i,
  input logic rst_ni,
  input logic spi_sclk_o,
  input logic spi_cs0_no,
  input logic spi_cs1_no,
  input logic spi_mosi_o,
  input logic pmem_we_o,
  input logic boot_done_o,
  input logic boot_error_o
);
  localparam int GAP = (CS_HIGH_NS + CLK_PERIOD_NS - 1) / CLK_PERIOD_NS;
  localparam int CW  = $clog2(GAP + 2);

  logic [CW-1:0] hi_cnt;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                     hi_cnt <= '0;
    else if (!spi_cs0_no)            hi_cnt <= '0;
    else if (hi_cnt != CW'(GAP + 1)) hi_cnt <= hi_cnt + 1'b1;
  end

  a_r8_cs1_high: assert property (@(posedge clk_i) disable iff (!rst_ni) spi_cs1_no);
  a_r1_sclk_idle: assert property (@(posedge clk_i) disable iff (!rst_ni) spi_cs0_no |-> !spi_sclk_o);
  a_r1_mosi_stable: assert property (@(posedge clk_i) disable iff (!rst_ni) spi_sclk_o |-> $stable(spi_mosi_o));
  a_r9_cs_gap: assert property (@(posedge clk_i) disable iff (!rst_ni) $fell(spi_cs0_no) |-> hi_cnt >= CW'(GAP));
  a_r5_we_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni) pmem_we_o |=> !pmem_we_o);
  a_r6_done_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni) boot_done_o |=> boot_done_o);
  a_r6_done_with_write: assert property (@(posedge clk_i) disable iff (!rst_ni) $rose(boot_done_o) |-> pmem_we_o);
  a_r7_error_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni) boot_error_o |=> boot_error_o);
  a_r7_error_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni) boot_error_o |-> (!boot_done_o && !pmem_we_o && spi_cs0_no));
endmodule

bind spi_boot_loader spi_boot_loader_chk #(
  .CLK_PERIOD_NS (CLK_PERIOD_NS),
  .CS_HIGH_NS    (CS_HIGH_NS)
) i_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .spi_sclk_o   (spi_sclk_o),
  .spi_cs0_no   (spi_cs0_no),
  .spi_cs1_no   (spi_cs1_no),
  .spi_mosi_o   (spi_mosi_o),
  .pmem_we_o    (pmem_we_o),
  .boot_done_o  (boot_done_o),
  .boot_error_o (boot_error_o)
);

// File: tb/test_spi_boot_loader.sv
module test_spi_boot_loader;
  localparam int CLK_PERIOD = 10;
  localparam int CLK_DIV    = 4;
  localparam int MEM_DEPTH  = 64;
  localparam int AW         = $clog2(MEM_DEPTH);
  localparam int CS_NS      = 300;

  logic clk = 1'b0, rst_n = 1'b0;
  logic sclk, cs0_n, cs1_n, mosi, miso = 1'b0;
  logic [AW-1:0] waddr;
  logic [7:0] wdata;
  logic we, done, err;

  spi_boot_loader #(.CLK_DIV(CLK_DIV), .CLK_PERIOD_NS(CLK_PERIOD), .CS_HIGH_NS(CS_NS),
                    .MEM_DEPTH(MEM_DEPTH)) i_spi_boot_loader (
    .clk_i(clk), .rst_ni(rst_n), .spi_sclk_o(sclk), .spi_cs0_no(cs0_n), .spi_cs1_no(cs1_n),
    .spi_mosi_o(mosi), .spi_miso_i(miso), .pmem_addr_o(waddr), .pmem_data_o(wdata),
    .pmem_we_o(we), .boot_done_o(done), .boot_error_o(err));

  always #(CLK_PERIOD/2) clk = ~clk;

  int n_chk = 0, n_fail = 0;
  task automatic chk(bit ok, string req, string what, longint act, longint exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
    end
  endtask

  // flash content and header
  logic [7:0] hdr [8];
  int seed = 0;
  function automatic logic [7:0] fbyte(int unsigned a);
    if (a < 8) return hdr[a];
    return 8'((a * 13) + (a >> 8) + 32'(seed));
  endfunction

  // behavioural flash model on chip select 0
  int bitcnt = 0, txn_n = 0;
  logic [7:0] sh = '0;
  logic [23:0] rd_addr = '0;
  logic [7:0] pre [2][5];
  int dbytes [2];
  time last_rise = 0;

  always @(negedge cs0_n) begin
    bitcnt = 0;
    chk($time - last_rise >= CS_NS, "R9", "cs0 high time ns", $time - last_rise, CS_NS);
  end
  always @(posedge cs0_n) if (rst_n) begin
    last_rise = $time;
    if (bitcnt > 0) txn_n++;
  end
  always @(posedge sclk) if (!cs0_n && rst_n) begin
    int b;
    sh = {sh[6:0], mosi};
    bitcnt++;
    if (bitcnt % 8 == 0) begin
      b = bitcnt / 8 - 1;
      if (b < 5 && txn_n < 2) pre[txn_n][b] = sh;
      if (b >= 1 && b <= 3) rd_addr = {rd_addr[15:0], sh};
      if (b >= 5 && txn_n < 2) dbytes[txn_n]++;
    end
  end
  always @(negedge sclk) if (!cs0_n && bitcnt >= 40) begin
    int idx;
    logic [7:0] v;
    idx = bitcnt - 40;
    v = fbyte(32'(rd_addr) + 32'(idx / 8));
    miso = v[7 - idx % 8];
  end

  // cycle-by-cycle reference comparison
  bit exp_ok = 0, live = 0;
  int wr_seen = 0, exp_len = 0, hi_run = 0;
  logic [23:0] exp_addr = '0;
  always @(negedge clk) if (rst_n && live) begin
    chk(cs1_n === 1'b1, "R8", "cs1 level", cs1_n, 1);
    if (cs0_n) chk(sclk === 1'b0, "R1", "sclk idle with cs high", sclk, 0);
    if (sclk) hi_run++;
    else if (hi_run > 0) begin
      chk(hi_run == CLK_DIV / 2, "R1", "sclk high cycles", hi_run, CLK_DIV / 2);
      hi_run = 0;
    end
    if (we) begin
      chk(exp_ok, "R7", "write while header invalid", 1, 0);
      chk(waddr == AW'(wr_seen), "R5", "write address", waddr, wr_seen);
      chk(wdata == fbyte(32'(exp_addr) + 32'(wr_seen)), "R5", "write data", wdata,
          fbyte(32'(exp_addr) + 32'(wr_seen)));
      wr_seen++;
    end
    chk(done === (exp_ok && wr_seen == exp_len), "R6", "done level", done,
        exp_ok && wr_seen == exp_len);
  end

  task automatic run(logic [23:0] a, logic [7:0] junk, logic [31:0] len, bit ok, int s);
    hdr[0] = a[7:0]; hdr[1] = a[15:8]; hdr[2] = a[23:16]; hdr[3] = junk;
    hdr[4] = len[7:0]; hdr[5] = len[15:8]; hdr[6] = len[23:16]; hdr[7] = len[31:24];
    seed = s; exp_ok = ok; exp_addr = a; exp_len = int'(len);
    live = 0;
    rst_n = 0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk(cs0_n && cs1_n && !sclk && !we && !done && !err, "R10", "reset outputs",
        {cs0_n, cs1_n, sclk, we, done, err}, 6'b110000);
    wr_seen = 0; txn_n = 0; bitcnt = 0; hi_run = 0;
    dbytes[0] = 0; dbytes[1] = 0;
    for (int t = 0; t < 2; t++) for (int k = 0; k < 5; k++) pre[t][k] = 8'hxx;
    rst_n = 1; live = 1; last_rise = $time;
    for (int c = 0; c < 20000 && !done && !err; c++) @(negedge clk);
    repeat (300) @(negedge clk);
    chk(pre[0][0] == 8'h0B, "R2", "header opcode", pre[0][0], 8'h0B);
    chk({pre[0][1], pre[0][2], pre[0][3]} == 24'h0, "R2", "header address",
        {pre[0][1], pre[0][2], pre[0][3]}, 0);
    chk(dbytes[0] == 8, "R2", "header data bytes", dbytes[0], 8);
    if (ok) begin
      chk(txn_n == 2, "R4", "transaction count", txn_n, 2);
      chk(pre[1][0] == 8'h0B, "R4", "image opcode", pre[1][0], 8'h0B);
      chk({pre[1][1], pre[1][2], pre[1][3]} == a, "R3", "image address decode",
          {pre[1][1], pre[1][2], pre[1][3]}, a);
      chk(dbytes[1] == exp_len, "R3", "image length decode", dbytes[1], exp_len);
      chk(wr_seen == exp_len, "R5", "write count", wr_seen, exp_len);
      chk(done && !err, "R6", "done held", {done, err}, 2'b10);
    end else begin
      chk(txn_n == 1, "R7", "transaction count", txn_n, 1);
      chk(wr_seen == 0, "R7", "write count", wr_seen, 0);
      chk(err && !done, "R7", "error held", {done, err}, 2'b01);
    end
  endtask

  initial begin
    run(24'h012345, 8'hA5, 32'd5, 1'b1, 3);
    run(24'h0000A0, 8'h00, 32'd64, 1'b1, 7);           // full depth
    run(24'hFFFFF0, 8'h00, 32'd1, 1'b1, 11);           // single byte, top of flash
    run(24'h000100, 8'h00, 32'd0, 1'b0, 0);            // zero length
    run(24'h000100, 8'h00, 32'd65, 1'b0, 0);           // one past depth
    run(24'h000100, 8'h00, 32'h0100_0001, 1'b0, 0);    // large, low bits legal
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    chk(1'b0, "R6", "watchdog expired", 0, 1);
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule